// File: doc/BRIEF.md
# CPU-Cycle Down-Counting Interrupt Timer

This block is a 16-bit interrupt timer that steps once for every CPU cycle, where `cpu_tick` marks the cycle. Software sets it up with command writes. Each write carries a command index, a parameter byte and a strobe, and the address decoding in front of the block has already been done. Three indices matter:

- **13** is the control word.
- **14** loads the low counter byte.
- **15** loads the high counter byte.

All other indices are ignored.

When counting is enabled, the counter steps down once per CPU cycle. If it steps from 0x0000 to 0xFFFF while the interrupt enable is set, the active-low interrupt line goes low. The line stays low until software writes the control word again. In normal use, software loads N−1 into the counter, enables both bits, and clears the interrupt-enable bit inside its handler. The counter does not stop after a wrap, so a later wrap can raise the interrupt again.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset, irq_n is high, both enables are clear, the counter is 0 and no interrupt is pending.
- R2: A write with index 13 takes bit 0 of the parameter as interrupt enable and bit 7 as count enable. Bits 6:1 are ignored, and indices 0 to 12 change nothing.
- R3: Index 14 writes the parameter into counter bits 7:0. Index 15 writes it into counter bits 15:8.
- R4: The counter decreases by one on each clock edge where cpu_tick and count enable are both high. On any other edge it holds, unless a byte is loaded.
- R5: A step from 0x0000 to 0xFFFF with interrupt enable set drives irq_n low after that edge. Loading N−1 and then enabling both bits gives the interrupt on the Nth counted cycle.
- R6: Once low, irq_n stays low until a control write occurs.
- R7: Any control write clears a pending interrupt, and irq_n is high after that edge. A control write wins over a wrap on the same edge.
- R8: A wrap with interrupt enable clear raises no interrupt.
- R9: The counter keeps stepping after a wrap, and a later wrap re-raises the interrupt: 65536 counted cycles after the previous one.
- R10: A byte load on the same edge as a decrement wins for the loaded byte. The other byte takes its decremented value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | High for one clock per CPU cycle |
| cmd_we | input | 1 | Command write strobe |
| cmd_idx | input | 4 | Decoded command index |
| cmd_data | input | 8 | Command parameter byte |
| irq_n | output | 1 | Active-low interrupt, held until acknowledged |

## Verification
A counter-byte load can land on the same edge as a decrement. The bench provokes this by writing one byte while counting runs. It judges the outcome by the exact cycle on which irq_n falls, because the fall cycle shows whether the loaded byte survived intact and the other byte was decremented. A second collision puts a control write on the very edge of a wrap. For that case the bench expects irq_n to stay high.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int CMD_IDX_W    = 4;
  localparam int CMD_DATA_W   = 8;
  localparam int CMD_CTRL     = 13;
  localparam int CMD_CNT_BASE = 14;  // low byte, then high byte
  localparam int CTRL_IRQ_BIT = 0;
  localparam int CTRL_CNT_BIT = 7;
endpackage

// File: rtl/timer_cmd_decode.sv
module timer_cmd_decode
  import irq_timer_pkg::*;
#(
  parameter int IDX_W = CMD_IDX_W,
  parameter int NB    = 2
) (
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  output logic             ctrl_we,
  output logic [NB-1:0]    byte_ld
);
  assign ctrl_we = we && (idx == IDX_W'(CMD_CTRL));

  for (genvar b = 0; b < NB; b++) begin : g_ld
    assign byte_ld[b] = we && (idx == IDX_W'(CMD_CNT_BASE + b));
  end

  always_comb begin
    assert (!(ctrl_we && (byte_ld != '0))) else $error("AST_ONE_CMD");  // R2
  end
endmodule

// File: rtl/timer_down_counter.sv
module timer_down_counter #(
  parameter int DATA_W = 8,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [NB-1:0]     byte_ld,
  input  logic [DATA_W-1:0] data,
  output logic              wrap
);
  localparam int CNT_W = DATA_W * NB;

  logic [CNT_W-1:0] cnt, dec, nxt;

  assign dec  = cnt - CNT_W'(1);
  assign wrap = step && (cnt == '0);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign nxt[b*DATA_W +: DATA_W] = byte_ld[b] ? data
                                   : (step ? dec[b*DATA_W +: DATA_W]
                                           : cnt[b*DATA_W +: DATA_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && byte_ld == '0) |=> $stable(cnt)) else $error("AST_HOLD_IDLE");  // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && byte_ld == '0) |=> (cnt == $past(cnt) - CNT_W'(1))) else $error("AST_STEP_DOWN");  // R4
  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ld[0] |=> (cnt[DATA_W-1:0] == $past(data))) else $error("AST_LOAD_LOW");  // R10
  AST_WRAP_TO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && byte_ld == '0) |=> (cnt == {CNT_W{1'b1}})) else $error("AST_WRAP_TO_MAX");  // R9
endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic irq_en_in,
  input  logic cnt_en_in,
  input  logic wrap,
  output logic cnt_en,
  output logic pending
);
  logic irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= 1'b0;
      cnt_en  <= 1'b0;
      pending <= 1'b0;
    end else if (ctrl_we) begin
      irq_en  <= irq_en_in;
      cnt_en  <= cnt_en_in;
      pending <= 1'b0;
    end else if (wrap && irq_en) begin
      pending <= 1'b1;
    end
  end

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ctrl_we) |=> pending) else $error("AST_IRQ_HELD");  // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !pending) else $error("AST_ACK_CLEARS");  // R7
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !irq_en) |=> !pending) else $error("AST_NO_IRQ_DISABLED");  // R8
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int DATA_W = CMD_DATA_W,
  parameter int IDX_W  = CMD_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tick,
  input  logic              cmd_we,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              irq_n
);
  localparam int NB = 2;

  logic          ctrl_we, cnt_en, pending, wrap;
  logic [NB-1:0] byte_ld;

  timer_cmd_decode #(.IDX_W(IDX_W), .NB(NB)) u_dec (
    .we(cmd_we), .idx(cmd_idx), .ctrl_we(ctrl_we), .byte_ld(byte_ld)
  );

  timer_down_counter #(.DATA_W(DATA_W), .NB(NB)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(cpu_tick && cnt_en),
    .byte_ld(byte_ld), .data(cmd_data), .wrap(wrap)
  );

  timer_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
    .irq_en_in(cmd_data[CTRL_IRQ_BIT]), .cnt_en_in(cmd_data[CTRL_CNT_BIT]),
    .wrap(wrap), .cnt_en(cnt_en), .pending(pending)
  );

  assign irq_n = !pending;

  AST_FALL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(wrap)) else $error("AST_FALL_ON_WRAP");  // R5
  AST_RISE_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(ctrl_we)) else $error("AST_RISE_ON_CTRL");  // R6
endmodule

// File: tb/tb_cyc_irq_timer.sv
module tb_cyc_irq_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_tick = 1'b1;
  logic       cmd_we = 1'b0;
  logic [3:0] cmd_idx = '0;
  logic [7:0] cmd_data = '0;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cyc_irq_timer dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .cmd_we(cmd_we),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic exp_v);
    checks++;
    if (irq_n !== exp_v) begin
      errors++;
      $display("FAIL %s: irq_n actual=%b expected=%b at %0t", req, irq_n, exp_v, $time);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    cmd_we = 1'b1; cmd_idx = i; cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] lo, input logic [7:0] hi);
    wr(4'd13, 8'h00); wr(4'd14, lo); wr(4'd15, hi);
  endtask

  task automatic t_reset;
    chk("R1 reset", 1'b1);
  endtask

  task automatic t_n_minus_one;
    setup(8'h04, 8'h00);
    wr(4'd13, 8'h81);
    edges(4); chk("R5 before Nth cycle", 1'b1);
    edges(1); chk("R5 on Nth cycle", 1'b0);
    edges(10); chk("R6 held", 1'b0);
    wr(4'd13, 8'h80); chk("R7 ack", 1'b1);
  endtask

  task automatic t_ctrl_bits;
    setup(8'h00, 8'h00);
    wr(4'd13, 8'h7E); edges(3); chk("R2 bits 6:1 ignored", 1'b1);
    wr(4'd13, 8'h7F); edges(3); chk("R2 irq en only, no count", 1'b1);
    wr(4'd5, 8'h81); edges(3); chk("R2 other index ignored", 1'b1);
    wr(4'd13, 8'h81); edges(1); chk("R2 enables, counter still 0", 1'b0);
  endtask

  task automatic t_tick_gate;
    setup(8'h01, 8'h00);
    cpu_tick = 1'b0;
    wr(4'd13, 8'h81); edges(10); chk("R4 no tick holds", 1'b1);
    cpu_tick = 1'b1; edges(1); cpu_tick = 1'b0;
    edges(3); chk("R4 one tick", 1'b1);
    cpu_tick = 1'b1; edges(1);
    chk("R4 second tick wraps", 1'b0);
  endtask

  task automatic t_irq_disabled;
    setup(8'h00, 8'h00);
    wr(4'd13, 8'h80); edges(5); chk("R8 wrap without irq enable", 1'b1);
    wr(4'd13, 8'h81); edges(3); chk("R8 no late irq", 1'b1);
  endtask

  task automatic t_rewrap;
    setup(8'h01, 8'h00);
    wr(4'd13, 8'h81);
    edges(1); chk("R9 first wrap pending", 1'b1);
    edges(1); chk("R9 first wrap", 1'b0);
    wr(4'd13, 8'h81); chk("R9 ack", 1'b1);
    edges(65534); chk("R9 before rewrap", 1'b1);
    edges(1); chk("R9 rewrap", 1'b0);
  endtask

  task automatic t_load_priority;
    setup(8'h05, 8'h00);
    wr(4'd13, 8'h81);
    edges(1);
    wr(4'd14, 8'h02);
    edges(1); chk("R10 low load wins", 1'b1);
    edges(1); chk("R10 low load wins", 1'b1);
    edges(1); chk("R10 low load wrap", 1'b0);
    setup(8'h03, 8'h07);
    wr(4'd13, 8'h81);
    edges(1);
    wr(4'd15, 8'h00);
    edges(1); chk("R10 high load, low decremented", 1'b1);
    edges(1); chk("R3 R10 high load wrap", 1'b0);
  endtask

  task automatic t_ack_collision;
    setup(8'h01, 8'h00);
    wr(4'd13, 8'h81);
    edges(1);
    wr(4'd13, 8'h81); chk("R7 ack beats wrap", 1'b1);
    edges(4); chk("R7 stays released", 1'b1);
  endtask

  task automatic t_reset_mid;
    setup(8'h00, 8'h00);
    wr(4'd13, 8'h81); edges(1); chk("R1 pre-reset irq", 1'b0);
    rst_n = 1'b0; edges(1); chk("R1 reset releases", 1'b1);
    rst_n = 1'b1; edges(5); chk("R1 enables cleared", 1'b1);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_n_minus_one();
    t_ctrl_bits();
    t_tick_gate();
    t_irq_disabled();
    t_load_priority();
    t_ack_collision();
    t_rewrap();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule